// File: doc/BRIEF.md
# BCH Error Locator Engine

This block turns the BCH syndromes of one protected flash block into the bit positions of the errors in that block. It never sees the block data. Software, or a neighbouring syndrome generator, writes the syndromes through an indexed write port, chooses a correction strength of 4, 8 or 16 bits, and pulses `start`. The engine then solves the key equation with an inversion-free Berlekamp-Massey loop that is built around one shared GF(2^13) multiplier. After that it runs a serial root search with one candidate position per cycle, from bit 0 up to the last bit of the block.

When the engine finishes, it raises a sticky interrupt. It also publishes an error count, an uncorrectable flag, and an ascending list of error positions that can be read back by index. The strength is latched at `start`, so each block can use a different level. An all-zero syndrome set finishes straight away, without the search.

Top module: `bch_err_locator`

## Requirements
- R1: `cfg_level` is latched at `start`. The value 0 selects t=4, 1 selects t=8, and 2 or 3 selects t=16. Only syndrome slots 0..2t-1 are used. Slot j-1 holds S_j, which is the sum over the error positions p of alpha^(j*p).
- R2: Arithmetic is done in GF(2^13), where alpha is a root of x^13+x^4+x^3+x+1. An error at bit p, for any p from 0 through BLOCK_BITS-1 (8183 by default, parity area included), is reported as location p.
- R3: A block with n errors, where n is at most t, finishes with `uncorrectable`=0 and `err_cnt`=n. List entries 0..n-1 hold the positions in ascending order. An entry is read by driving `loc_sel`, and `loc_rdata` shows it after one clock edge.
- R4: A block is flagged `uncorrectable`=1 in two cases: the locator polynomial length exceeds t, or the number of roots found in the block differs from that length. In both cases `err_cnt` reads 0.
- R5: When syndromes 0..2t-1 are all zero, the run ends on the second clock edge after `start`, with `err_cnt`=0 and `uncorrectable`=0.
- R6: `busy` rises on the edge that accepts `start` and stays high for the whole run. `irq` rises on the same edge where `busy` falls.
- R7: `irq` stays high until an `irq_clr` strobe clears it.
- R8: Syndrome writes and `start` pulses that arrive while `busy` is high are ignored.
- R9: After reset, `busy`, `irq`, `err_cnt` and `uncorrectable` are all 0.
- R10: While the engine is idle, `err_cnt` and `uncorrectable` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | 2 | Correction strength select, latched at start |
| syn_we | input | 1 | Syndrome write strobe |
| syn_sel | input | 5 | Syndrome slot index |
| syn_wdata | input | 13 | Syndrome value |
| start | input | 1 | Begin location for the stored syndromes |
| irq_clr | input | 1 | Write-one strobe that clears the interrupt |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Sticky completion interrupt |
| err_cnt | output | 5 | Number of located errors |
| uncorrectable | output | 1 | Block exceeds the selected strength |
| loc_sel | input | 4 | Location list read index |
| loc_rdata | output | 13 | Registered location list entry |

## Verification
The assertions take `start` and `irq_clr` to be strobes from a well-behaved host. They place no demands on the syndrome values. For syndromes that do not match a binary error pattern they only require that the flags remain coherent: a zero count whenever the block is uncorrectable, and results that stay frozen while the engine is idle. To produce matching syndromes, the bench computes every syndrome set from a chosen list of in-range error positions with its own field multiplier. The uncorrectable cases use two hand-built syndrome sets whose locator length and root count can be derived by hand. The bench keeps `cfg_level` and the syndromes steady until `start`, except in the one scenario that deliberately writes during a run.

// File: rtl/bch_gf_pkg.sv
package bch_gf_pkg;
  localparam int M      = 13;
  localparam logic [M-1:0] POLY_LOW = 13'h001B;  // x^4+x^3+x+1
  localparam logic [M-1:0] ALPHA_INV = 13'h100D; // x^12+x^3+x^2+1
  localparam int T_MAX  = 16;
  localparam int NSYN   = 2 * T_MAX;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  typedef logic [M-1:0] gf_t;

  // Horner-style shift-and-reduce product
  function automatic gf_t gf_mul(input gf_t a, input gf_t b);
    gf_t acc;
    acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY_LOW : '0);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic gf_t gf_ainv_pow(input int k);
    gf_t r;
    r = gf_t'(1);
    for (int j = 0; j < k; j++) r = gf_mul(r, ALPHA_INV);
    return r;
  endfunction
endpackage

// File: rtl/bch_gf_mult.sv
module bch_gf_mult
  import bch_gf_pkg::*;
(
  input  gf_t a,
  input  gf_t b,
  output gf_t p
);
  always_comb p = gf_mul(a, b);
endmodule

// File: rtl/bch_kes.sv
module bch_kes
  import bch_gf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic [4:0]               t_val,
  input  logic [NSYN-1:0][M-1:0]   syn,
  output logic [T_MAX:0][M-1:0]    lam,
  output logic [5:0]               deg,
  output logic                     done
);
  typedef enum logic [2:0] {K_IDLE, K_DISC, K_DEC, K_UPA, K_UPB, K_NEXT} kst_t;
  kst_t st;

  logic [T_MAX:0][M-1:0] bb;
  logic [5:0] r;
  logic [4:0] i;
  logic [4:0] sidx;
  logic [5:0] t2m1;
  gf_t delta, gamma, tmp, prevb, op_a, op_b, prod;
  logic grow;

  assign t2m1 = {t_val, 1'b0} - 6'd1;
  assign sidx = r[4:0] - i;

  bch_gf_mult u_mul (.a(op_a), .b(op_b), .p(prod));

  // one multiplier, operands chosen by phase
  always_comb begin
    op_a = '0;
    op_b = '0;
    case (st)
      K_DISC: begin
        op_a = lam[i];
        op_b = ({1'b0, i} <= r) ? syn[sidx] : '0;
      end
      K_UPA: begin op_a = gamma; op_b = lam[i]; end
      K_UPB: begin op_a = delta; op_b = prevb;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= K_IDLE; done <= 1'b0; deg <= '0; r <= '0; i <= '0;
      delta <= '0; gamma <= '0; tmp <= '0; prevb <= '0; grow <= 1'b0;
      lam <= '0; bb <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        K_IDLE: if (go) begin
          for (int k = 0; k <= T_MAX; k++) begin
            lam[k] <= (k == 0) ? gf_t'(1) : '0;
            bb[k]  <= (k == 0) ? gf_t'(1) : '0;
          end
          deg <= '0; gamma <= gf_t'(1); r <= '0; i <= '0; delta <= '0;
          st <= K_DISC;
        end
        K_DISC: begin
          delta <= delta ^ prod;
          if (i == t_val) st <= K_DEC;
          else i <= i + 5'd1;
        end
        K_DEC: begin
          grow  <= (delta != '0) && ({deg, 1'b0} <= {1'b0, r});
          i     <= '0;
          prevb <= '0;
          st    <= K_UPA;
        end
        K_UPA: begin
          tmp <= prod;
          st  <= K_UPB;
        end
        K_UPB: begin
          lam[i] <= tmp ^ prod;
          bb[i]  <= grow ? lam[i] : prevb;
          prevb  <= bb[i];
          if (i == t_val) st <= K_NEXT;
          else begin i <= i + 5'd1; st <= K_UPA; end
        end
        K_NEXT: begin
          if (grow) begin
            deg   <= r + 6'd1 - deg;
            gamma <= delta;
          end
          if (r == t2m1) begin
            done <= 1'b1;
            st   <= K_IDLE;
          end else begin
            r <= r + 6'd1; i <= '0; delta <= '0; st <= K_DISC;
          end
        end
        default: st <= K_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_root_scan.sv
module bch_root_scan
  import bch_gf_pkg::*;
#(
  parameter int BLOCK_BITS = 8184
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [T_MAX:0][M-1:0] lam,
  output logic                  hit,
  output gf_t                   hit_pos,
  output logic                  done
);
  localparam gf_t LAST = M'(BLOCK_BITS - 1);

  logic [T_MAX:0][M-1:0] term, nxt;
  gf_t pos, sum;
  logic run, last_q;

  // each term steps by a fixed power of alpha^-1
  for (genvar k = 0; k <= T_MAX; k++) begin : g_step
    localparam gf_t STEP = gf_ainv_pow(k);
    assign nxt[k] = gf_mul(term[k], STEP);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k <= T_MAX; k++) sum = sum ^ term[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; hit <= 1'b0; hit_pos <= '0; done <= 1'b0;
      last_q <= 1'b0; pos <= '0; term <= '0;
    end else begin
      hit    <= 1'b0;
      last_q <= 1'b0;
      done   <= last_q;
      if (go) begin
        term <= lam;
        pos  <= '0;
        run  <= 1'b1;
      end else if (run) begin
        hit     <= (sum == '0);
        hit_pos <= pos;
        term    <= nxt;
        if (pos == LAST) begin
          run    <= 1'b0;
          last_q <= 1'b1;
        end else begin
          pos <= pos + gf_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bch_err_locator.sv
module bch_err_locator
  import bch_gf_pkg::*;
#(
  parameter int BLOCK_BITS = 8184
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cfg_level,
  input  logic        syn_we,
  input  logic [4:0]  syn_sel,
  input  logic [12:0] syn_wdata,
  input  logic        start,
  input  logic        irq_clr,
  output logic        busy,
  output logic        irq,
  output logic [4:0]  err_cnt,
  output logic        uncorrectable,
  input  logic [3:0]  loc_sel,
  output logic [12:0] loc_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_KES, S_SCAN} st_t;
  st_t st;

  logic [NSYN-1:0][M-1:0] syn;
  logic [T_MAX:0][M-1:0]  lam;
  logic [5:0]             kes_deg;
  logic                   kes_go, kes_done, scan_go, scan_hit, scan_done;
  gf_t                    scan_pos;
  logic [4:0]             t_q;
  logic [CNT_W-1:0]       cnt;
  logic                   syn_nz;
  gf_t                    locs [T_MAX];

  function automatic logic [4:0] level_to_t(input logic [1:0] lv);
    case (lv)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  always_comb begin
    syn_nz = 1'b0;
    for (int k = 0; k < NSYN; k++)
      if (k < 2 * int'(t_q)) syn_nz = syn_nz | (|syn[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) syn <= '0;
    else if (syn_we && st == S_IDLE) syn[syn_sel] <= syn_wdata;
  end

  bch_kes u_kes (
    .clk(clk), .rst(rst), .go(kes_go), .t_val(t_q), .syn(syn),
    .lam(lam), .deg(kes_deg), .done(kes_done)
  );

  bch_root_scan #(.BLOCK_BITS(BLOCK_BITS)) u_scan (
    .clk(clk), .rst(rst), .go(scan_go), .lam(lam),
    .hit(scan_hit), .hit_pos(scan_pos), .done(scan_done)
  );

  // location list: one write port, registered read
  always_ff @(posedge clk) begin
    if (st == S_SCAN && scan_hit && cnt < CNT_W'(T_MAX)) locs[cnt[3:0]] <= scan_pos;
    loc_rdata <= locs[loc_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; busy <= 1'b0; irq <= 1'b0; err_cnt <= '0;
      uncorrectable <= 1'b0; t_q <= 5'd4; cnt <= '0;
      kes_go <= 1'b0; scan_go <= 1'b0;
    end else begin
      kes_go  <= 1'b0;
      scan_go <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1; t_q <= level_to_t(cfg_level); cnt <= '0;
          err_cnt <= '0; uncorrectable <= 1'b0; st <= S_CHECK;
        end
        S_CHECK: begin
          if (!syn_nz) begin
            busy <= 1'b0; irq <= 1'b1; st <= S_IDLE;
          end else begin
            kes_go <= 1'b1; st <= S_KES;
          end
        end
        S_KES: if (kes_done) begin
          if (kes_deg > {1'b0, t_q}) begin
            uncorrectable <= 1'b1; busy <= 1'b0; irq <= 1'b1; st <= S_IDLE;
          end else begin
            scan_go <= 1'b1; st <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (scan_hit) cnt <= cnt + CNT_W'(1);
          if (scan_done) begin
            uncorrectable <= ({1'b0, cnt} != kes_deg);
            err_cnt       <= ({1'b0, cnt} == kes_deg) ? cnt : '0;
            busy <= 1'b0; irq <= 1'b1; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_err_locator_chk.sv
module bch_err_locator_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cfg_level,
  input logic        syn_we,
  input logic [4:0]  syn_sel,
  input logic [12:0] syn_wdata,
  input logic        start,
  input logic        irq_clr,
  input logic        busy,
  input logic        irq,
  input logic [4:0]  err_cnt,
  input logic        uncorrectable,
  input logic [3:0]  loc_sel,
  input logic [12:0] loc_rdata
);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_irq_at_finish_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  assert_unc_zero_count_R4: assert property (@(posedge clk) disable iff (rst)
    uncorrectable |-> (err_cnt == 5'd0));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !uncorrectable) |-> (err_cnt <= 5'd16));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(err_cnt) && $stable(uncorrectable)));
endmodule

bind bch_err_locator bch_err_locator_chk u_chk (.*);

// File: tb/bch_err_locator_bench.sv
module bch_err_locator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_level = '0;
  logic        syn_we = 1'b0;
  logic [4:0]  syn_sel = '0;
  logic [12:0] syn_wdata = '0;
  logic        start = 1'b0;
  logic        irq_clr = 1'b0;
  logic        busy, irq, uncorrectable;
  logic [4:0]  err_cnt;
  logic [3:0]  loc_sel = '0;
  logic [12:0] loc_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int pl [16];
  int npl;
  logic [12:0] sv [32];

  always #2 clk = ~clk;

  bch_err_locator u_bch_err_locator (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // carry-less product then reduction by x^13+x^4+x^3+x+1
  function automatic logic [12:0] fmul(input logic [12:0] a, input logic [12:0] b);
    logic [24:0] p;
    p = '0;
    for (int i = 0; i < 13; i++) if (b[i]) p = p ^ ({12'b0, a} << i);
    for (int k = 24; k >= 13; k--) if (p[k]) p = p ^ (25'h201B << (k - 13));
    return p[12:0];
  endfunction

  function automatic logic [12:0] apow(input int e);
    logic [12:0] r;
    r = 13'd1;
    for (int i = 0; i < e; i++) r = fmul(r, 13'd2);
    return r;
  endfunction

  function automatic int tval(input int lv);
    return (lv == 0) ? 4 : (lv == 1) ? 8 : 16;
  endfunction

  task automatic make_syn(input int lv);
    logic [12:0] a, pw;
    for (int j = 0; j < 32; j++) sv[j] = '0;
    for (int e = 0; e < npl; e++) begin
      a  = apow(pl[e]);
      pw = a;
      for (int j = 0; j < 2 * tval(lv); j++) begin
        sv[j] = sv[j] ^ pw;
        pw = fmul(pw, a);
      end
    end
  endtask

  task automatic load_syn();
    for (int j = 0; j < 32; j++) begin
      @(negedge clk);
      syn_we = 1'b1; syn_sel = 5'(j); syn_wdata = sv[j];
    end
    @(negedge clk);
    syn_we = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic run(input int lv, input string req);
    int k;
    clear_irq();
    cfg_level = 2'(lv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {req, " R6 busy after start"}, busy, 1);
    k = 0;
    while (!irq && k < 30000) begin @(negedge clk); k++; end
    chk(irq == 1'b1, {req, " R6 irq at finish"}, irq, 1);
    chk(busy == 1'b0, {req, " R6 busy low at finish"}, busy, 0);
  endtask

  task automatic expect_ok(input string req);
    chk(uncorrectable == 1'b0, {req, " R3 not flagged"}, uncorrectable, 0);
    chk(int'(err_cnt) == npl, {req, " R3 count"}, err_cnt, npl);
    for (int e = 0; e < npl; e++) begin
      loc_sel = 4'(e);
      @(negedge clk);
      chk(int'(loc_rdata) == pl[e], {req, " R2 R3 location"}, loc_rdata, pl[e]);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(irq == 1'b0, "R9 irq", irq, 0);
    chk(err_cnt == 5'd0, "R9 count", err_cnt, 0);
    chk(uncorrectable == 1'b0, "R9 flag", uncorrectable, 0);
  endtask

  task automatic t_zero();
    npl = 0; make_syn(0); load_syn();
    clear_irq();
    cfg_level = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R5 fast finish irq", irq, 1);
    chk(busy == 1'b0, "R5 fast finish busy", busy, 0);
    chk(err_cnt == 5'd0, "R5 count", err_cnt, 0);
    chk(uncorrectable == 1'b0, "R5 flag", uncorrectable, 0);
  endtask

  task automatic t_single();
    npl = 1; pl[0] = 100;
    make_syn(0); load_syn(); run(0, "single"); expect_ok("R1 single t4");
  endtask

  task automatic t_edges();
    npl = 4; pl[0] = 0; pl[1] = 17; pl[2] = 4000; pl[3] = 8183;
    make_syn(0); load_syn(); run(0, "edges"); expect_ok("R2 edge bits t4");
  endtask

  task automatic t_eight();
    npl = 8;
    pl[0] = 3; pl[1] = 250; pl[2] = 999; pl[3] = 1500;
    pl[4] = 2600; pl[5] = 5000; pl[6] = 7000; pl[7] = 8100;
    make_syn(1); load_syn(); run(1, "eight"); expect_ok("R1 full t8");
  endtask

  task automatic t_sixteen();
    npl = 16;
    for (int e = 0; e < 16; e++) pl[e] = e * 511 + 7;
    make_syn(2); load_syn(); run(2, "sixteen"); expect_ok("R1 full t16");
  endtask

  task automatic t_levels();
    npl = 3; pl[0] = 42; pl[1] = 4242; pl[2] = 8000;
    make_syn(3); load_syn(); run(3, "lvl3"); expect_ok("R1 level code 3");
    run(1, "lvl1"); expect_ok("R1 level code 1");
  endtask

  task automatic t_len_over();
    // only S8 nonzero at t=4: length jumps to 8
    for (int j = 0; j < 32; j++) sv[j] = '0;
    sv[7] = 13'd1;
    load_syn(); run(0, "len");
    chk(uncorrectable == 1'b1, "R4 length above t", uncorrectable, 1);
    chk(err_cnt == 5'd0, "R4 zero count", err_cnt, 0);
  endtask

  task automatic t_root_miss();
    // only S1 nonzero: length 1 with a constant locator, no roots
    for (int j = 0; j < 32; j++) sv[j] = '0;
    sv[0] = 13'd1;
    load_syn(); run(0, "miss");
    chk(uncorrectable == 1'b1, "R4 root count mismatch", uncorrectable, 1);
    chk(err_cnt == 5'd0, "R4 zero count", err_cnt, 0);
  endtask

  task automatic t_irq_hold();
    npl = 1; pl[0] = 8183;
    make_syn(0); load_syn(); run(0, "irq");
    repeat (6) @(negedge clk);
    chk(irq == 1'b1, "R7 irq held", irq, 1);
    chk(err_cnt == 5'd1, "R10 count held", err_cnt, 1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
    chk(err_cnt == 5'd1, "R10 count after clear", err_cnt, 1);
  endtask

  task automatic t_busy_ignore();
    int k;
    npl = 1; pl[0] = 500;
    make_syn(0); load_syn();
    clear_irq();
    cfg_level = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int j = 0; j < 8; j++) begin
      syn_we = 1'b1; syn_sel = 5'(j); syn_wdata = 13'h0ABC; start = 1'b1;
      @(negedge clk);
    end
    syn_we = 1'b0; start = 1'b0;
    k = 0;
    while (!irq && k < 30000) begin @(negedge clk); k++; end
    chk(irq == 1'b1, "R8 run finished", irq, 1);
    expect_ok("R8 first run");
    run(0, "rerun"); expect_ok("R8 syndromes untouched");
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_single();
    t_edges();
    t_eight();
    t_sixteen();
    t_levels();
    t_len_over();
    t_root_miss();
    t_irq_hold();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule